// File: doc/BRIEF.md
# Double-Buffered Overlay Framebuffer Swap Controller

This block holds two framebuffer pages for a square 8-bit-per-pixel overlay. Its size is set by the parameter `DIM_W`: each page has 2^DIM_W by 2^DIM_W pixels, and `DIM_W = 8` gives the 256x256 full-size image. At any moment one page is being shown and the other is the back page that the host CPU draws into. CPU writes arrive as 16-bit words with per-byte lane enables. A write goes to the back page only, either through a direct window or through a transposed window in which the row and column halves of the offset trade places.

The CPU asks for a page exchange by writing a control word. The exchange is deferred until the next rising edge of vertical sync. The page that has just become the back page is then wiped to zero by hardware, one pixel per clock. While the wipe runs, CPU writes are refused and flagged.

A status word reports the pending request, the wipe in progress and an 8-bit count of vsync starts. An overlay-visibility bit blanks the pixel output without pausing any of this machinery. A registered display read port serves the pixel pipeline.

Top module: `fbsc_top`

## Requirements
- R1: A CPU write with `win_i`=0 stores lane 0 (`wr_data_i[7:0]`) at back-page offset `wr_addr_i` and lane 1 (`wr_data_i[15:8]`) at offset `wr_addr_i`+1 (wrapping within the page). A lane is written only when its bit in `wr_be_i` is 1.
- R2: A lane whose data byte is zero writes nothing, so the previous pixel value stays.
- R3: With `win_i`=1, a lane whose offset is {high half, low half} is stored at {low half, high half}. Each half is `DIM_W` bits wide.
- R4: Writing `ctrl_data_i` with bit 0 set makes status bit 15 read 1. The bit stays 1 until a swap takes place.
- R5: When `vsync_i` rises while a swap is pending and no wipe is running, the displayed and back pages exchange. In the cycle that follows, status bit 15 reads 0 (unless a new request arrived in that same cycle) and status bit 14 reads 1.
- R6: After a swap, status bit 14 stays 1 for exactly 2^(2*DIM_W) cycles. When it drops, every pixel of the new back page reads 0.
- R7: A CPU write while status bit 14 is 1 changes no pixel and sets the sticky output `err_o`, which only reset clears.
- R8: A vsync rising edge during a wipe does not swap. The request stays pending and is served by the first vsync rising edge after the wipe ends.
- R9: Status bits 7:0 increase by one on every rising edge of `vsync_i` and wrap from 255 to 0.
- R10: Control bit 1 written on any control write sets `ovl_en_o`. While it is 0, `pix_o` reads 0, but swaps, wipes and the counter still run.
- R11: After reset, `status_o` is 0, `err_o` is 0, `ovl_en_o` is 0, and the other status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Framebuffer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | CPU write strobe into the back page |
| win_i | input | 1 | 1 selects the transposed window |
| wr_addr_i | input | 2*DIM_W | Pixel offset of lane 0 |
| wr_data_i | input | 16 | Two pixel bytes, lane 0 in the low byte |
| wr_be_i | input | 2 | Lane enables |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_data_i | input | 16 | Bit 0 swap request, bit 1 overlay visible |
| vsync_i | input | 1 | Vertical sync level, start is its rising edge |
| rd_addr_i | input | 2*DIM_W | Display read offset |
| pix_o | output | 8 | Displayed pixel, one cycle after `rd_addr_i` |
| ovl_en_o | output | 1 | Overlay visibility |
| status_o | output | 16 | Bit 15 pending, bit 14 wiping, bits 7:0 vsync count |
| err_o | output | 1 | Sticky flag for a write refused during a wipe |

## Verification
The assertions check, on every cycle, the rules that govern the status word over time. A pending request may only end at a vsync start. A wipe may only begin from a pending request at a vsync start. A vsync start during a wipe never ends a request. Each wipe run lasts exactly the page depth. The counter steps by one per vsync start. A refused write raises the sticky error, and the blanked output is zero.

Only the bench's scenarios can show what lands in memory. This covers lane and window placement, zero-byte transparency, the contents of a wiped page, and the survival of a pixel whose write was refused. These are observed by swapping a page into view and reading it back through the display port.

// File: rtl/fbsc_pkg.sv
package fbsc_pkg;
  localparam int unsigned ST_PEND   = 15;
  localparam int unsigned ST_BUSY   = 14;
  localparam int unsigned CTRL_SWAP = 0;
  localparam int unsigned CTRL_OVL  = 1;
  localparam int unsigned PIX_W     = 8;
  localparam int unsigned CNT_W     = 8;
endpackage

// File: rtl/fbsc_vsync.sv
module fbsc_vsync
  import fbsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic vs_q;

  assign start_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      cnt_o <= '0;
    end else begin
      vs_q <= vsync_i;
      if (start_o) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/fbsc_swap_ctrl.sv
module fbsc_swap_ctrl #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          vs_start_i,
  output logic          pending_o,
  output logic          busy_o,
  output logic          disp_page_o,
  output logic [AW-1:0] clr_addr_o
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic swap;

  // a wipe in progress defers the swap to a later vsync start
  assign swap = vs_start_i & pending_o & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o   <= 1'b0;
      busy_o      <= 1'b0;
      disp_page_o <= 1'b0;
      clr_addr_o  <= '0;
    end else begin
      pending_o <= req_i | (pending_o & ~swap);
      if (swap) begin
        disp_page_o <= ~disp_page_o;
        busy_o      <= 1'b1;
        clr_addr_o  <= '0;
      end else if (busy_o) begin
        clr_addr_o <= clr_addr_o + 1'b1;
        if (clr_addr_o == LAST) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbsc_wr_path.sv
module fbsc_wr_path
  import fbsc_pkg::*;
#(
  parameter int unsigned DIM_W = 4,
  parameter int unsigned LANES = 2,
  localparam int unsigned AW   = 2 * DIM_W,
  localparam int unsigned DW   = PIX_W * LANES
) (
  input  logic                wr_i,
  input  logic                win_i,
  input  logic                busy_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic [LANES-1:0]    be_i,
  output logic [LANES-1:0]    we_o,
  output logic [LANES*AW-1:0] waddr_o,
  output logic [DW-1:0]       wdata_o,
  output logic                drop_o
);
  assign drop_o  = wr_i & busy_i;
  assign wdata_o = data_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0]    lin;
    logic [PIX_W-1:0] byte_v;

    assign lin    = addr_i + AW'(l);
    assign byte_v = data_i[l*PIX_W +: PIX_W];
    // zero pixel is transparent
    assign we_o[l] = wr_i & ~busy_i & be_i[l] & (byte_v != '0);
    assign waddr_o[l*AW +: AW] = win_i ? {lin[DIM_W-1:0], lin[AW-1:DIM_W]} : lin;
  end
endmodule

// File: rtl/fbsc_mem.sv
module fbsc_mem
  import fbsc_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned DW    = PIX_W * LANES
) (
  input  logic                clk_i,
  input  logic [LANES-1:0]    we_i,
  input  logic [LANES*AW-1:0] waddr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                back_page_i,
  input  logic                clr_en_i,
  input  logic [AW-1:0]       clr_addr_i,
  input  logic                disp_page_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [PIX_W-1:0]    rd_data_o
);
  logic [PIX_W-1:0] mem [2*DEPTH];

  always_ff @(posedge clk_i) begin
    if (clr_en_i) mem[{back_page_i, clr_addr_i}] <= '0;
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem[{back_page_i, waddr_i[l*AW +: AW]}] <= wdata_i[l*PIX_W +: PIX_W];
    end
    rd_data_o <= mem[{disp_page_i, rd_addr_i}];
  end
endmodule

// File: rtl/fbsc_top.sv
module fbsc_top
  import fbsc_pkg::*;
#(
  parameter int unsigned DIM_W = 4,
  localparam int unsigned AW   = 2 * DIM_W,
  localparam int unsigned LANES = 2,
  localparam int unsigned DW   = PIX_W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             win_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LANES-1:0] wr_be_i,
  input  logic             ctrl_wr_i,
  input  logic [15:0]      ctrl_data_i,
  input  logic             vsync_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             ovl_en_o,
  output logic [15:0]      status_o,
  output logic             err_o
);
  logic             vs_start;
  logic [CNT_W-1:0] vs_cnt;
  logic             pending, busy, disp_page;
  logic [AW-1:0]    clr_addr;
  logic [LANES-1:0] we;
  logic [LANES*AW-1:0] waddr;
  logic [DW-1:0]    wdata;
  logic             drop;
  logic [PIX_W-1:0] rd_data;
  logic             req;

  assign req = ctrl_wr_i & ctrl_data_i[CTRL_SWAP];

  fbsc_vsync u_vsync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .start_o (vs_start),
    .cnt_o   (vs_cnt)
  );

  fbsc_swap_ctrl #(.AW(AW)) u_swap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .vs_start_i  (vs_start),
    .pending_o   (pending),
    .busy_o      (busy),
    .disp_page_o (disp_page),
    .clr_addr_o  (clr_addr)
  );

  fbsc_wr_path #(.DIM_W(DIM_W), .LANES(LANES)) u_wr (
    .wr_i    (wr_i),
    .win_i   (win_i),
    .busy_i  (busy),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .be_i    (wr_be_i),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .drop_o  (drop)
  );

  fbsc_mem #(.AW(AW), .LANES(LANES)) u_mem (
    .clk_i       (clk_i),
    .we_i        (we),
    .waddr_i     (waddr),
    .wdata_i     (wdata),
    .back_page_i (~disp_page),
    .clr_en_i    (busy),
    .clr_addr_i  (clr_addr),
    .disp_page_i (disp_page),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_en_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (ctrl_wr_i) ovl_en_o <= ctrl_data_i[CTRL_OVL];
      if (drop)      err_o    <= 1'b1;
    end
  end

  assign pix_o = ovl_en_o ? rd_data : '0;

  always_comb begin
    status_o              = '0;
    status_o[ST_PEND]     = pending;
    status_o[ST_BUSY]     = busy;
    status_o[CNT_W-1:0]   = vs_cnt;
  end
endmodule

// File: rtl/fbsc_top_chk.sv
module fbsc_top_chk #(
  parameter int unsigned DIM_W = 4,
  localparam int unsigned AW   = 2 * DIM_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        vsync_i,
  input logic [7:0]  pix_o,
  input logic        ovl_en_o,
  input logic [15:0] status_o,
  input logic        err_o
);
  logic        vs_d;
  logic        vs_start;
  logic [AW:0] run_len;

  assign vs_start = vsync_i & ~vs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_d    <= 1'b0;
      run_len <= '0;
    end else begin
      vs_d    <= vsync_i;
      run_len <= status_o[14] ? run_len + 1'b1 : '0;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] && !vs_start |=> status_o[15]); // R4
  AST_SWAP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[14]) |-> $past(status_o[15]) && $past(vs_start)); // R5
  AST_CLEAR_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[14]) |-> run_len == (AW+1)'(DEPTH)); // R6
  AST_DROP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && status_o[14] |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_BUSY_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[14] && status_o[15] && vs_start |=> status_o[15]); // R8
  AST_VCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_start |=> status_o[7:0] == $past(status_o[7:0]) + 8'd1); // R9
  AST_VCNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_start |=> $stable(status_o[7:0])); // R9
  AST_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl_en_o |-> pix_o == 8'd0); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[13:8] == 6'd0); // R11
endmodule

bind fbsc_top fbsc_top_chk #(.DIM_W(DIM_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .vsync_i  (vsync_i),
  .pix_o    (pix_o),
  .ovl_en_o (ovl_en_o),
  .status_o (status_o),
  .err_o    (err_o)
);

// File: tb/fbsc_top_tb.sv
`timescale 1ns/1ps
module fbsc_top_tb;
  localparam int unsigned DIM_W = 4;
  localparam int unsigned AW    = 2 * DIM_W;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned NVEC  = 8;

  // {win, addr, data, be, chk_addr, exp}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 8'h10, 16'hBBAA, 2'b11, 8'h11, 8'hBB},
    {1'b0, 8'h20, 16'h2211, 2'b11, 8'h21, 8'h22},
    {1'b0, 8'h30, 16'h0055, 2'b11, 8'h31, 8'h00},
    {1'b0, 8'h40, 16'h7766, 2'b01, 8'h41, 8'h00},
    {1'b1, 8'h52, 16'h9988, 2'b11, 8'h35, 8'h99},
    {1'b0, 8'h10, 16'h00CC, 2'b11, 8'h10, 8'hCC},
    {1'b1, 8'h60, 16'h4433, 2'b11, 8'h06, 8'h33},
    {1'b0, 8'h00, 16'h0000, 2'b11, 8'h00, 8'h00}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0, win_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic [1:0]    wr_be_i = '0;
  logic          ctrl_wr_i = 1'b0;
  logic [15:0]   ctrl_data_i = '0;
  logic          vsync_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    pix_o;
  logic          ovl_en_o;
  logic [15:0]   status_o;
  logic          err_o;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_cnt = '0;

  always #4 clk_i = ~clk_i;

  fbsc_top #(.DIM_W(DIM_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic w, input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk_i);
    wr_i = 1'b1; win_i = w; wr_addr_i = a; wr_data_i = d; wr_be_i = be;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_ctrl(input logic [15:0] d);
    @(negedge clk_i);
    ctrl_wr_i = 1'b1; ctrl_data_i = d;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic vs_pulse();
    @(negedge clk_i);
    vsync_i = 1'b1;
    @(negedge clk_i);
    vsync_i = 1'b0;
    exp_cnt = exp_cnt + 8'd1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk_i);
    rd_addr_i = a;
    @(negedge clk_i);
    v = pix_o;
  endtask

  task automatic wait_idle();
    while (status_o[14]) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    logic [7:0] c0;
    repeat (3) @(negedge clk_i);
    chk("R11 status after reset", 32'(status_o), 32'h0);
    chk("R11 err after reset", 32'(err_o), 32'h0);
    chk("R11 overlay after reset", 32'(ovl_en_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    do_ctrl(16'h0002);
    chk("R10 overlay on", 32'(ovl_en_o), 32'h1);
    chk("R4 no request yet", 32'(status_o[15]), 32'h0);
    do_ctrl(16'h0003);
    chk("R4 pending set", 32'(status_o[15]), 32'h1);
    repeat (5) @(negedge clk_i);
    chk("R4 pending held", 32'(status_o[15]), 32'h1);

    vs_pulse();
    chk("R5 R9 status after swap", 32'(status_o), 32'(16'h4000 | 16'(exp_cnt)));
    n = 0;
    while (status_o[14]) begin n++; @(negedge clk_i); end
    chk("R6 wipe length", 32'(n), 32'(DEPTH));

    do_ctrl(16'h0003);
    vs_pulse();
    wait_idle();

    // table walk: all writes into back page, then bring it into view
    for (int i = 0; i < NVEC; i++)
      do_wr(VEC[i][42], VEC[i][41:34], VEC[i][33:18], VEC[i][17:16]);
    do_ctrl(16'h0003);
    vs_pulse();
    wait_idle();
    for (int i = 0; i < NVEC; i++) begin
      rd(VEC[i][15:8], v);
      chk($sformatf("R1 R2 R3 vector %0d", i), 32'(v), 32'(VEC[i][7:0]));
    end

    // refused write and deferred swap during a wipe
    do_wr(1'b0, 8'h77, 16'h003C, 2'b01);
    do_ctrl(16'h0003);
    vs_pulse();
    chk("R5 wipe started", 32'(status_o[15:14]), 32'h1);
    repeat (3) @(negedge clk_i);
    do_wr(1'b0, 8'h00, 16'h00A5, 2'b01);
    chk("R7 err raised", 32'(err_o), 32'h1);
    do_ctrl(16'h0003);
    vs_pulse();
    chk("R8 no swap during wipe", 32'(status_o[15:14]), 32'h3);
    chk("R9 count during wipe", 32'(status_o[7:0]), 32'(exp_cnt));
    wait_idle();
    chk("R8 still pending after wipe", 32'(status_o[15]), 32'h1);
    rd(8'h77, v);
    chk("R1 pixel on shown page", 32'(v), 32'h3C);
    vs_pulse();
    chk("R8 swap after wipe", 32'(status_o[15:14]), 32'h1);
    rd(8'h00, v);
    chk("R7 refused pixel absent", 32'(v), 32'h00);
    rd(8'h10, v);
    chk("R6 wiped pixel", 32'(v), 32'h00);
    rd(8'h35, v);
    chk("R6 wiped transposed pixel", 32'(v), 32'h00);
    chk("R7 err sticky", 32'(err_o), 32'h1);
    wait_idle();

    // overlay off: swap still runs, output blanked
    do_wr(1'b0, 8'h44, 16'h0066, 2'b01);
    do_ctrl(16'h0001);
    chk("R10 overlay off", 32'(ovl_en_o), 32'h0);
    vs_pulse();
    chk("R10 swap while hidden", 32'(status_o[15:14]), 32'h1);
    rd(8'h44, v);
    chk("R10 blanked pixel", 32'(v), 32'h00);
    do_ctrl(16'h0002);
    rd(8'h44, v);
    chk("R10 visible pixel", 32'(v), 32'h66);
    wait_idle();

    c0 = status_o[7:0];
    repeat (256) vs_pulse();
    chk("R9 wrap after 256", 32'(status_o[7:0]), 32'(c0));
    vs_pulse();
    chk("R9 step after wrap", 32'(status_o[7:0]), 32'(c0 + 8'd1));
    chk("R4 R5 no swap without request", 32'(status_o[15:14]), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule